// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block buffers received serial characters for a 16550-style UART. The deserializer hands it one byte per valid strobe, or a strobe that says a break was seen. The host side pops the oldest byte through a data-register read strobe and clears sticky line-status flags through a line-status read strobe. A control-register write path selects between queued mode and single-holding-register mode, sets the interrupt trigger level and flushes the queues.

The block counts bit-period ticks and derives the character time from the frame format. When the queue has held data for four character times without a receive or a read, it raises a timeout-pending flag. The interrupt controller that turns these flags into an interrupt priority sits outside the block.

Top module: `uart_rx_queue`

## Requirements
- R1: In queued mode (retained control bit 0 = 1) up to 16 bytes are held in arrival order. `rd_data_o` shows the oldest byte and `count_o` shows the fill level. A `data_rd_i` strobe on a non-empty queue removes the oldest byte one cycle later.
- R2: In queued mode, a byte that arrives while 16 bytes are held and no read happens in the same cycle is dropped. The stored bytes and the count stay as they were, and `overrun_o` is 1 from the next cycle.
- R3: In holding mode (retained control bit 0 = 0) at most one byte is held. A byte that arrives while one is held and no read happens replaces it, and `overrun_o` is set.
- R4: Control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queued mode `trig_o` = (count >= level). In holding mode `trig_o` = (count != 0).
- R5: A control write keeps only bits 7, 6, 3 and 0 of the written value (mask 0xC9), and `ctl_o` shows them. A write whose value equals `ctl_o` changes nothing and flushes nothing.
- R6: A control write with bit 1 set empties the receive queue and clears the timeout flag in the same edge. A write with bit 2 set pulses `tx_flush_o` high for one cycle after the write. A write that changes bit 0 does both.
- R7: One character time is 7 + `data_bits_i` + `parity_en_i` + `two_stop_i` bit ticks (1 start bit, 5 to 8 data bits, optional parity, 1 or 2 stop bits). In queued mode the timer restarts on every accepted byte, and on every read that leaves data in the queue. After 4 character times of `bit_tick_i` pulses it sets `timeout_o`, but only if the queue is not empty at that moment.
- R8: Any `data_rd_i` strobe clears `timeout_o`.
- R9: A `brk_det_i` strobe pushes a 0x00 byte and sets `break_o`. It takes precedence over a byte strobe in the same cycle. `data_ready_o` is 1 exactly when the count is non-zero.
- R10: A read that leaves the queue empty clears `break_o`. A `lsr_rd_i` strobe clears both `break_o` and `overrun_o`. A set event in the same cycle wins over a clear.
- R11: A read of an empty queue leaves the count at 0, and `rd_data_o` reads 0x00 while the queue is empty.
- R12: After reset the count is 0, `ctl_o` is 0x00 (holding mode), all status flags are 0 and `tx_flush_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_byte_i | input | 8 | Received byte from the deserializer |
| rx_valid_i | input | 1 | Strobe: `rx_byte_i` holds a new byte |
| brk_det_i | input | 1 | Strobe: a break condition was received |
| data_rd_i | input | 1 | Strobe: host reads the data register |
| lsr_rd_i | input | 1 | Strobe: host reads the line status register |
| ctl_wr_i | input | 1 | Strobe: control register write |
| ctl_data_i | input | 8 | Control write value |
| bit_tick_i | input | 1 | One pulse per serial bit period |
| data_bits_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Parity bit present in the frame |
| two_stop_i | input | 1 | Two stop bits |
| rd_data_o | output | 8 | Oldest byte, 0x00 when empty |
| count_o | output | 5 | Number of bytes held |
| data_ready_o | output | 1 | Queue not empty |
| break_o | output | 1 | Break received, sticky |
| overrun_o | output | 1 | Byte lost, sticky |
| timeout_o | output | 1 | Character timeout pending |
| trig_o | output | 1 | Fill level has reached the trigger level |
| ctl_o | output | 8 | Retained control value |
| tx_flush_o | output | 1 | One-cycle request to flush the transmit queue |

## Verification
Every output except `tx_flush_o` is a function of held state, so a corrupted pointer or count shows at the ports on the very next cycle. It appears as a wrong head byte on `rd_data_o`, a wrong fill level on `count_o`, or a `trig_o` crossing at the wrong level. A timer that is off by even one tick moves the rise of `timeout_o` by one cycle. The per-cycle comparison against a behavioural queue model therefore catches both off-by-one limits and a wrong character-length sum. Sticky flags with the wrong set-over-clear order show up only when set and clear strobes coincide, so the random phase drives such collisions often.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [7:0] CTL_KEEP  = 8'hC9;
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_RXCLR = 1;
  localparam int unsigned CTL_TXCLR = 2;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_level(input trig_sel_e sel, input int unsigned depth);
    case (sel)
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctl_o,
  output logic       fifo_en_o,
  output trig_sel_e  trig_sel_o,
  output logic       rx_flush_o,
  output logic       tx_flush_o
);
  logic [7:0] ctl_q;
  logic       tx_flush_q;
  logic       changed, en_tog;

  assign changed    = wr_i && (wdata_i != ctl_q);
  assign en_tog     = changed && (wdata_i[CTL_EN] != ctl_q[CTL_EN]);
  assign rx_flush_o = changed && (wdata_i[CTL_RXCLR] || en_tog);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      tx_flush_q <= 1'b0;
    end else begin
      if (changed) ctl_q <= wdata_i & CTL_KEEP;
      tx_flush_q <= changed && (wdata_i[CTL_TXCLR] || en_tog);
    end
  end

  assign ctl_o      = ctl_q;
  assign fifo_en_o  = ctl_q[CTL_EN];
  assign trig_sel_o = trig_sel_e'(ctl_q[7:6]);
  assign tx_flush_o = tx_flush_q;

  // R5: rewriting the held value is a no-op
  a_r5_same_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wdata_i == ctl_q) |=> $stable(ctl_q) && !tx_flush_q);

  // R6: enable change requests a transmit flush
  a_r6_en_tog_txflush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wdata_i[CTL_EN] != ctl_q[CTL_EN]) |=> tx_flush_q);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             single_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_req_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             pop_o,
  output logic             ovr_evt_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count_q;
  logic             full_eff, acc, ovwr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_eff  = single_i ? (count_q != '0) : (count_q == CW'(DEPTH));
  assign pop_o     = pop_req_i && (count_q != '0) && !flush_i;
  assign acc       = push_i && !flush_i && (!full_eff || pop_o);
  assign ovwr      = push_i && !flush_i && full_eff && !pop_o && single_i;
  assign ovr_evt_o = push_i && !flush_i && full_eff && !pop_o;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic we;
    assign we = (acc && (wr_ptr == AW'(i))) || (ovwr && (rd_ptr == AW'(i)));
    always_ff @(posedge clk_i) begin
      if (we) mem[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (acc)   wr_ptr <= ptr_inc(wr_ptr);
      if (pop_o) rd_ptr <= ptr_inc(rd_ptr);
      count_q <= count_q + CW'(acc) - CW'(pop_o);
    end
  end

  assign head_o  = (count_q != '0) ? mem[rd_ptr] : '0;
  assign count_o = count_q;

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  // R2: full queue keeps level and head on a lost byte
  a_r2_full_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_i && (count_q == CW'(DEPTH)) && push_i && !pop_req_i && !flush_i
    |=> (count_q == CW'(DEPTH)) && $stable(head_o));

  a_r3_single_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i && !flush_i |=> count_q <= CW'(1) || !single_i);

  a_r11_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) && pop_req_i && !push_i && !flush_i |=> count_q == '0);
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int unsigned CHARS = 4,
  localparam int unsigned MAXBITS = 12,
  localparam int unsigned TW = $clog2(MAXBITS * CHARS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] data_bits_i,
  input  logic       parity_en_i,
  input  logic       two_stop_i,
  input  logic       restart_i,
  input  logic       flush_i,
  input  logic       rd_i,
  input  logic       nonempty_i,
  output logic       pend_o
);
  logic [3:0]    char_bits;
  logic [TW-1:0] limit, cnt_q;
  logic          armed_q, pend_q, expire;

  // start + 5 data + 1 stop = 7 fixed bits
  assign char_bits = 4'd7 + {2'b00, data_bits_i} + {3'b000, parity_en_i} + {3'b000, two_stop_i};
  assign limit     = TW'(char_bits) * TW'(CHARS);
  assign expire    = armed_q && tick_i && !restart_i && !flush_i && ((cnt_q + 1'b1) >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (flush_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (restart_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && tick_i) begin
        if (expire) armed_q <= 1'b0;
        else        cnt_q   <= cnt_q + 1'b1;
      end
      if (rd_i || flush_i)          pend_q <= 1'b0;
      else if (expire && nonempty_i) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !pend_q);

  a_r7_pend_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(nonempty_i));

  a_r6_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pend_q);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TIMEOUT_CHARS = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    rx_byte_i,
  input  logic          rx_valid_i,
  input  logic          brk_det_i,
  input  logic          data_rd_i,
  input  logic          lsr_rd_i,
  input  logic          ctl_wr_i,
  input  logic [7:0]    ctl_data_i,
  input  logic          bit_tick_i,
  input  logic [1:0]    data_bits_i,
  input  logic          parity_en_i,
  input  logic          two_stop_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          data_ready_o,
  output logic          break_o,
  output logic          overrun_o,
  output logic          timeout_o,
  output logic          trig_o,
  output logic [7:0]    ctl_o,
  output logic          tx_flush_o
);
  logic          fifo_en, rx_flush, pop, ovr_evt, push_req, restart;
  trig_sel_e     trig_sel;
  logic [7:0]    push_data;
  logic [CW-1:0] count, trig_lvl;
  logic          brk_q, ovr_q;

  rxq_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr_i),
    .wdata_i    (ctl_data_i),
    .ctl_o      (ctl_o),
    .fifo_en_o  (fifo_en),
    .trig_sel_o (trig_sel),
    .rx_flush_o (rx_flush),
    .tx_flush_o (tx_flush_o)
  );

  assign push_req  = brk_det_i || rx_valid_i;
  assign push_data = brk_det_i ? 8'h00 : rx_byte_i;

  rxq_store #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (rx_flush),
    .single_i    (!fifo_en),
    .push_i      (push_req),
    .push_data_i (push_data),
    .pop_req_i   (data_rd_i),
    .head_o      (rd_data_o),
    .count_o     (count),
    .pop_o       (pop),
    .ovr_evt_o   (ovr_evt)
  );

  assign restart = fifo_en && !rx_flush && (push_req || (pop && (count > CW'(1))));

  rxq_timer #(.CHARS(TIMEOUT_CHARS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (bit_tick_i),
    .data_bits_i (data_bits_i),
    .parity_en_i (parity_en_i),
    .two_stop_i  (two_stop_i),
    .restart_i   (restart),
    .flush_i     (rx_flush),
    .rd_i        (data_rd_i),
    .nonempty_i  (count != '0),
    .pend_o      (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (brk_det_i && !rx_flush) brk_q <= 1'b1;
      else if (lsr_rd_i || rx_flush || (data_rd_i && !push_req && (count <= CW'(1))))
        brk_q <= 1'b0;
      if (ovr_evt)       ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
    end
  end

  assign trig_lvl     = CW'(trig_level(trig_sel, DEPTH));
  assign trig_o       = fifo_en ? (count >= trig_lvl) : (count != '0);
  assign count_o      = count;
  assign data_ready_o = (count != '0);
  assign break_o      = brk_q;
  assign overrun_o    = ovr_q;

  a_r2_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> overrun_o);

  a_r9_break_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_det_i && !rx_flush |=> break_o && data_ready_o);

  a_r10_lsr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !brk_det_i && !ovr_evt |=> !break_o && !overrun_o);

  a_r3_holding_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |-> count <= CW'(1));
endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0, brk = 1'b0, data_rd = 1'b0, lsr_rd = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic       bit_tick = 1'b0, tick_on = 1'b0;
  logic [1:0] data_bits = '0;
  logic       parity_en = 1'b0, two_stop = 1'b0;
  logic [7:0] rd_data, ctl_o;
  logic [4:0] count;
  logic       dr, brk_o, ovr_o, tout_o, trig_o, txf_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
    .brk_det_i(brk), .data_rd_i(data_rd), .lsr_rd_i(lsr_rd), .ctl_wr_i(ctl_wr),
    .ctl_data_i(ctl_data), .bit_tick_i(bit_tick), .data_bits_i(data_bits),
    .parity_en_i(parity_en), .two_stop_i(two_stop), .rd_data_o(rd_data),
    .count_o(count), .data_ready_o(dr), .break_o(brk_o), .overrun_o(ovr_o),
    .timeout_o(tout_o), .trig_o(trig_o), .ctl_o(ctl_o), .tx_flush_o(txf_o)
  );

  // behavioural reference
  int m_q[$];
  int m_ctl, m_brk, m_ovr, m_pend, m_armed, m_tcnt, m_txf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_ctl = 0; m_brk = 0; m_ovr = 0; m_pend = 0;
      m_armed = 0; m_tcnt = 0; m_txf = 0;
    end else begin
      int flush, tog, nctl, fen, preq, pdat, pop, n0, full, ovr_set, restart, expire, limit;
      flush = 0; tog = 0; nctl = m_ctl;
      m_txf = 0;
      if (ctl_wr && ctl_data != m_ctl) begin
        tog   = (ctl_data[0] != m_ctl[0]);
        flush = ctl_data[1] | tog;
        m_txf = ctl_data[2] | tog;
        nctl  = ctl_data & 8'hC9;
      end
      fen  = m_ctl & 1;
      n0   = m_q.size();
      preq = !flush && (brk || rx_valid);
      pdat = brk ? 0 : rx_byte;
      pop  = !flush && data_rd && n0 > 0;
      full = fen ? (n0 == 16) : (n0 != 0);
      ovr_set = preq && full && !pop;
      restart = fen && !flush && (preq || (pop && n0 > 1));
      limit   = (7 + data_bits + parity_en + two_stop) * 4;
      expire  = m_armed && bit_tick && !restart && !flush && (m_tcnt + 1 >= limit);
      if (flush) m_q.delete();
      else begin
        if (pop) void'(m_q.pop_front());
        if (preq) begin
          if (!full || pop) m_q.push_back(pdat);
          else if (!fen) m_q[0] = pdat;
        end
      end
      if (brk && !flush) m_brk = 1;
      else if (lsr_rd || flush || (data_rd && !(brk || rx_valid) && n0 <= 1)) m_brk = 0;
      if (ovr_set) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
      if (data_rd || flush) m_pend = 0;
      else if (expire && n0 != 0) m_pend = 1;
      if (flush) begin m_armed = 0; m_tcnt = 0; end
      else if (restart) begin m_armed = 1; m_tcnt = 0; end
      else if (m_armed && bit_tick) begin
        if (expire) m_armed = 0; else m_tcnt++;
      end
      m_ctl = nctl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_trig();
    int lv;
    case (m_ctl[7:6])
      2'b00: lv = 1; 2'b01: lv = 4; 2'b10: lv = 8; default: lv = 14;
    endcase
    return (m_ctl & 1) ? (m_q.size() >= lv) : (m_q.size() != 0);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 rd_data model", rd_data, m_q.size() ? m_q[0] : 0);
      chk("R1 count model", count, m_q.size());
      chk("R9 data_ready model", dr, m_q.size() != 0);
      chk("R10 break model", brk_o, m_brk);
      chk("R2 overrun model", ovr_o, m_ovr);
      chk("R7 timeout model", tout_o, m_pend);
      chk("R4 trig model", trig_o, m_trig());
      chk("R5 ctl model", ctl_o, m_ctl);
      chk("R6 tx_flush model", txf_o, m_txf);
    end
  end

  initial forever begin
    @(negedge clk);
    bit_tick = tick_on;
  end

  task automatic clr();
    rx_valid = 0; brk = 0; data_rd = 0; lsr_rd = 0; ctl_wr = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic put(input logic [7:0] b);
    @(negedge clk); clr(); rx_byte = b; rx_valid = 1;
  endtask
  task automatic rd1();
    @(negedge clk); clr(); data_rd = 1;
  endtask
  task automatic lsr1();
    @(negedge clk); clr(); lsr_rd = 1;
  endtask
  task automatic brk1();
    @(negedge clk); clr(); brk = 1;
  endtask
  task automatic wctl(input logic [7:0] v);
    @(negedge clk); clr(); ctl_wr = 1; ctl_data = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    // R12 reset state
    chk("R12 count", count, 0); chk("R12 ctl", ctl_o, 0); chk("R12 flags",
      {dr, brk_o, ovr_o, tout_o, trig_o, txf_o}, 0);
    chk("R12 rd_data", rd_data, 0);

    wctl(8'h01); idle(1);
    chk("R5 ctl enable", ctl_o, 8'h01);
    chk("R6 enable toggle tx flush", txf_o, 1);
    put(8'h5A); put(8'hA5); put(8'h3C); idle(1);
    chk("R1 count 3", count, 3); chk("R1 head", rd_data, 8'h5A); chk("R4 trig lvl1", trig_o, 1);
    rd1(); idle(1);
    chk("R1 next head", rd_data, 8'hA5); chk("R1 count 2", count, 2);
    rd1(); rd1(); idle(1);
    chk("R1 empty", count, 0);
    rd1(); idle(1);
    chk("R11 empty read count", count, 0); chk("R11 empty read data", rd_data, 0);

    wctl(8'h41); idle(1);
    put(1); put(2); put(3); idle(1);
    chk("R4 lvl4 below", trig_o, 0);
    put(4); idle(1);
    chk("R4 lvl4 reached", trig_o, 1);
    wctl(8'h83); idle(1);
    chk("R6 rx flush", count, 0); chk("R5 mask", ctl_o, 8'h81);
    for (int i = 0; i < 7; i++) put(8'(i));
    idle(1); chk("R4 lvl8 below", trig_o, 0);
    put(8'h07); idle(1); chk("R4 lvl8 reached", trig_o, 1);
    wctl(8'hC3); idle(1);
    for (int i = 0; i < 13; i++) put(8'(i));
    idle(1); chk("R4 lvl14 below", trig_o, 0);
    put(8'h0D); idle(1); chk("R4 lvl14 reached", trig_o, 1);
    wctl(8'hC1); idle(1);
    chk("R5 same value no flush", count, 14); chk("R5 same value no tx flush", txf_o, 0);
    wctl(8'hCF); idle(1);
    chk("R5 retained bits", ctl_o, 8'hC9); chk("R6 tx flush pulse", txf_o, 1);
    chk("R6 rx flushed", count, 0);
    idle(1); chk("R6 tx flush one cycle", txf_o, 0);

    wctl(8'h03); idle(1);
    for (int i = 0; i < 16; i++) put(8'(8'h10 + i));
    put(8'hEE); idle(1);
    chk("R2 full count", count, 16); chk("R2 overrun", ovr_o, 1); chk("R2 head kept", rd_data, 8'h10);
    lsr1(); idle(1); chk("R10 lsr clears overrun", ovr_o, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); clr();
      chk("R2 order kept", rd_data, 8'h10 + i);
      data_rd = 1;
    end
    idle(1); chk("R1 drained", count, 0);

    data_bits = 2'd3; parity_en = 1; two_stop = 1; tick_on = 1;
    put(8'h77); idle(40); chk("R7 not yet 48", tout_o, 0);
    idle(12); chk("R7 expired 48", tout_o, 1);
    rd1(); idle(1); chk("R8 read clears", tout_o, 0);
    data_bits = 2'd0; parity_en = 0; two_stop = 0;
    put(8'h01); put(8'h02); idle(24); chk("R7 not yet 28", tout_o, 0);
    idle(8); chk("R7 expired 28", tout_o, 1);
    rd1(); idle(1); chk("R8 read clears again", tout_o, 0);
    idle(20); chk("R7 restarted by read", tout_o, 0);
    idle(12); chk("R7 expiry after read restart", tout_o, 1);
    rd1(); put(8'h03); rd1(); idle(60);
    chk("R7 empty at expiry", tout_o, 0); chk("R7 empty count", count, 0);

    put(8'h11); brk1(); idle(1);
    chk("R9 break count", count, 2); chk("R9 break set", brk_o, 1);
    rd1(); idle(1); chk("R9 break byte zero", rd_data, 0); chk("R10 break held", brk_o, 1);
    rd1(); idle(1); chk("R10 empty read clears break", brk_o, 0);
    brk1(); idle(1); chk("R9 data ready", dr, 1);
    lsr1(); idle(1); chk("R10 lsr clears break", brk_o, 0); chk("R10 count kept", count, 1);
    rd1(); idle(1);

    wctl(8'h00); idle(1);
    chk("R6 disable tx flush", txf_o, 1); chk("R5 holding", ctl_o, 0);
    put(8'h21); put(8'h22); idle(1);
    chk("R3 single count", count, 1); chk("R3 replaced", rd_data, 8'h22); chk("R3 overrun", ovr_o, 1);
    rd1(); lsr1(); idle(1);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); clr();
      rx_byte  = 8'($urandom);
      rx_valid = ($urandom % 100) < 35;
      data_rd  = ($urandom % 100) < 25;
      brk      = ($urandom % 100) < 2;
      lsr_rd   = ($urandom % 100) < 5;
      if (($urandom % 100) < 2) begin
        ctl_wr = 1;
        case ($urandom % 8)
          0: ctl_data = 8'h01; 1: ctl_data = 8'h41; 2: ctl_data = 8'h81; 3: ctl_data = 8'hC1;
          4: ctl_data = 8'h03; 5: ctl_data = 8'h00; 6: ctl_data = 8'hC9; default: ctl_data = 8'h07;
        endcase
      end
      if (($urandom % 100) < 2) begin
        data_bits = 2'($urandom); parity_en = 1'($urandom); two_stop = 1'($urandom);
      end
      if (($urandom % 100) < 3) tick_on = ~tick_on;
      if (c % 500 < 200) begin rx_valid = 0; data_rd = 0; tick_on = 1; end
    end
    idle(2);
    finish_run();
  end
endmodule